// File: doc/BRIEF.md
# Rate-Controlled Errored Packet Injector

This block picks which outgoing packets a downstream framer should deliberately corrupt, for example by inverting the frame check sequence, so that a far-end receiver's error counters can be tested. It watches a one-cycle packet-start event on the transmit path. For each packet it decides whether the packet is errored, and reports the decision as a one-cycle corrupt pulse. It never touches packet bytes.

A control write loads a seven-bit rate code, an eight-bit run length and a manual-mode bit. The rate code is a mantissa times a power of ten. The low four bits hold the mantissa x and the upper three bits hold the exponent y. One packet in every x·10^y is errored. Exponents above a parameterised ceiling (six by default) are clamped to that ceiling. The run length limits how many rate-driven errors are produced, and the value 0xFF means the run never ends. Every write aborts any run in progress and starts a new one from the new values.

Independently of the rate run, a rising edge on the manual error input arms a single error for the next packet. This only happens while the stored manual-mode bit and the global manual enable are both set. The event pins are plain single-cycle strobes with no handshake: the block never stalls the packet stream, and it answers every packet start in a fixed cycle.

Top module: `eri_injector`

## Requirements
- R1: After reset, `pkt_corrupt` and `run_active` are 0, and no packet is corrupted until a write or a manual event arms one.
- R2: After a write with mantissa x != 0 and count N != 0, the P-th, 2P-th, ... packet starts are errored, where P = x·10^min(y, EXP_MAX). With the default ceiling, code 0x01 errors every packet, 0x0F every 15th packet and 0x11 every 10th packet.
- R3: Any exponent code at or above EXP_MAX gives the same period as EXP_MAX. With the default ceiling, codes 6 and 7 both give 10^6.
- R4: A write with mantissa 0 stops rate injection: `run_active` is 0 in the cycle after the write, and no later packet is rate-errored.
- R5: A write during an active run discards the old run's progress, and packet counting restarts from the packet after the write under the new code and count.
- R6: With N in 1..0xFE, exactly N rate errors are produced, after which `run_active` falls in the cycle after the last one. A write with N = 0 starts no run.
- R7: With N = 0xFF, rate errors continue indefinitely and `run_active` stays 1.
- R8: A 0-to-1 transition on `man_err` marks the next packet start as errored only when the stored manual-mode bit and `glb_man_en` are both 1. Otherwise the transition is ignored.
- R9: Several manual edges before one packet start give a single errored packet. An edge in the same cycle as a packet start applies to the following packet instead.
- R10: Manual and rate injection work together. A packet wanted by both gives one pulse, and manual errors do not use up the rate count N.
- R11: `pkt_corrupt` is a one-cycle pulse, asserted only in the cycle after the `pkt_start` it refers to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_rate | input | 7 | Rate code: [6:4] exponent, [3:0] mantissa |
| cfg_num | input | 8 | Rate-driven error count; 0xFF = unlimited |
| cfg_man_mode | input | 1 | Manual-mode bit, stored on write |
| glb_man_en | input | 1 | Global manual-injection enable |
| man_err | input | 1 | Manual error request, rising-edge active |
| pkt_start | input | 1 | One-cycle strobe at each packet start |
| pkt_corrupt | output | 1 | Pulse: corrupt the packet just started |
| run_active | output | 1 | A rate-driven run is in progress |

## Verification
The bench sweeps rate codes whose periods run from 1 to several thousand packets, and it predicts every packet's fate arithmetically. A wrong period multiplier or a missing exponent clamp would shift the errored packet index. An off-by-one packet counter would error the packet just before or after the right one. A wrong finite count would give one error too many or too few, and a run that ignored 0xFF would stop. The bench restarts a run mid-stream, which catches a design that kept the old counter. For the manual path it checks three things. Disabled edges must produce nothing. Repeated edges must merge into one error. An edge that coincides with a packet start must hit the following packet. A design that wrongly charged manual errors to the rate count would end its run early.

// File: rtl/eri_pkg.sv
package eri_pkg;
  // Default geometry of the control word.
  localparam int DEF_MANT_W  = 4;
  localparam int DEF_EXP_W   = 3;
  localparam int DEF_EXP_MAX = 6;
  localparam int DEF_NUM_W   = 8;
  localparam int DEF_CNT_W   = 24;

  // Split view of a rate code with the default geometry.
  typedef struct packed {
    logic [DEF_EXP_W-1:0]  expo;
    logic [DEF_MANT_W-1:0] mant;
  } rate_code_t;

  // Which source asked for the current error (used for clarity in the top).
  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_RATE   = 2'b01,
    SRC_MANUAL = 2'b10,
    SRC_BOTH   = 2'b11
  } err_src_e;
endpackage

// File: rtl/eri_period_calc.sv
// Converts a mantissa/exponent pair to a packet period, clamping the exponent.
module eri_period_calc #(
  parameter int MANT_W  = 4,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 6,
  parameter int CNT_W   = 24
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [CNT_W-1:0]  period
);
  localparam logic [CNT_W-1:0] TEN = CNT_W'(10);

  // Multiply by ten once per exponent step, up to the ceiling.
  always_comb begin
    period = CNT_W'(mant);
    for (int k = 0; k < EXP_MAX; k++) begin
      if (k < int'(expo)) period = period * TEN;
    end
  end
endmodule

// File: rtl/eri_rate_engine.sv
// Packet interval counter and remaining-error counter for a rate-driven run.
module eri_rate_engine #(
  parameter int CNT_W = 24,
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_ok,
  input  logic [CNT_W-1:0] period_in,
  input  logic [NUM_W-1:0] num_in,
  input  logic             pkt_start,
  output logic             hit,
  output logic             active
);
  localparam logic [NUM_W-1:0] NUM_FOREVER = {NUM_W{1'b1}};
  localparam logic [NUM_W-1:0] NUM_ONE     = NUM_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] rem_q;

  // A write takes priority over a packet in the same cycle.
  assign hit = active && pkt_start && !load && (cnt_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      period_q <= CNT_ONE;
      cnt_q    <= CNT_ONE;
      rem_q    <= '0;
    end else if (load) begin
      active   <= load_ok && (num_in != '0);
      period_q <= period_in;
      cnt_q    <= period_in;
      rem_q    <= num_in;
    end else if (active && pkt_start) begin
      if (cnt_q == CNT_ONE) begin
        cnt_q <= period_q;
        if (rem_q != NUM_FOREVER) begin
          rem_q <= rem_q - NUM_ONE;
          if (rem_q == NUM_ONE) active <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q != '0) && (cnt_q <= period_q));
  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_ok) |=> !active);
  p_last_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rem_q == NUM_ONE) |=> !active);
  p_forever_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem_q == NUM_FOREVER && !load) |=> active);
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_ok && num_in != '0) |=> active && (cnt_q == period_q));
endmodule

// File: rtl/eri_manual_arm.sv
// Rising-edge detector with a one-deep pending flag consumed by the next packet.
module eri_manual_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic man_in,
  input  logic arm_ok,
  input  logic take,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = man_in && !prev_q && arm_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= man_in;
      // A new edge survives a same-cycle take: it targets the following packet.
      pend   <= (pend && !take) || rise;
    end
  end

  p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_ok && !pend) |=> !pend);
  p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend);
endmodule

// File: rtl/eri_injector.sv
// Top: decides per packet whether the downstream stage should corrupt it.
module eri_injector
  import eri_pkg::*;
#(
  parameter int MANT_W  = DEF_MANT_W,
  parameter int EXP_W   = DEF_EXP_W,
  parameter int EXP_MAX = DEF_EXP_MAX,
  parameter int NUM_W   = DEF_NUM_W,
  parameter int CNT_W   = DEF_CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [MANT_W+EXP_W-1:0]  cfg_rate,
  input  logic [NUM_W-1:0]         cfg_num,
  input  logic                     cfg_man_mode,
  input  logic                     glb_man_en,
  input  logic                     man_err,
  input  logic                     pkt_start,
  output logic                     pkt_corrupt,
  output logic                     run_active
);
  localparam int RATE_W = MANT_W + EXP_W;

  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic [CNT_W-1:0]  period;
  logic              rate_hit;
  logic              man_pend;
  logic              man_mode_q;
  logic              corrupt_q;
  err_src_e          src;

  assign mant = cfg_rate[MANT_W-1:0];
  assign expo = cfg_rate[RATE_W-1:MANT_W];

  eri_period_calc #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .CNT_W(CNT_W)
  ) u_period (
    .mant  (mant),
    .expo  (expo),
    .period(period)
  );

  eri_rate_engine #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_we),
    .load_ok  (mant != '0),
    .period_in(period),
    .num_in   (cfg_num),
    .pkt_start(pkt_start),
    .hit      (rate_hit),
    .active   (run_active)
  );

  eri_manual_arm u_man (
    .clk   (clk),
    .rst_n (rst_n),
    .man_in(man_err),
    .arm_ok(man_mode_q && glb_man_en),
    .take  (pkt_start),
    .pend  (man_pend)
  );

  assign src = err_src_e'({man_pend && pkt_start, rate_hit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      man_mode_q <= 1'b0;
      corrupt_q  <= 1'b0;
    end else begin
      if (cfg_we) man_mode_q <= cfg_man_mode;
      corrupt_q <= (src != SRC_NONE);
    end
  end

  assign pkt_corrupt = corrupt_q;

  p_pulse_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_corrupt |-> $past(pkt_start));
  p_manual_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && man_pend) |=> pkt_corrupt);
  p_rate_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_hit |=> pkt_corrupt);
endmodule

// File: tb/tb_eri_injector.sv
`timescale 1ns/1ps
module tb_eri_injector;
  localparam int EXPC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_rate = '0;
  logic [7:0] cfg_num = '0;
  logic       cfg_man_mode = 1'b0;
  logic       glb_man_en = 1'b0;
  logic       man_err = 1'b0;
  logic       pkt_start = 1'b0;
  logic       pkt_corrupt;
  logic       run_active;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eri_injector #(.EXP_MAX(EXPC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rate(cfg_rate),
    .cfg_num(cfg_num), .cfg_man_mode(cfg_man_mode), .glb_man_en(glb_man_en),
    .man_err(man_err), .pkt_start(pkt_start), .pkt_corrupt(pkt_corrupt),
    .run_active(run_active)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [6:0] rate, input logic [7:0] num, input logic mm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rate = rate; cfg_num = num; cfg_man_mode = mm;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One packet: strobe, sample the verdict, then confirm the pulse is one cycle.
  task automatic send_pkt(output logic got);
    @(negedge clk);
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    got = pkt_corrupt;
    @(negedge clk);
    check("R11", pkt_corrupt, 1'b0);
  endtask

  task automatic man_pulse();
    @(negedge clk);
    man_err = 1'b1;
    @(negedge clk);
    man_err = 1'b0;
  endtask

  function automatic int period_of(input logic [6:0] code);
    int p = int'(code[3:0]);
    int e = int'(code[6:4]);
    if (e > EXPC) e = EXPC;
    for (int k = 0; k < e; k++) p = p * 10;
    return p;
  endfunction

  task automatic run_rate(input logic [6:0] code, input logic [7:0] num,
                          input int npk, input string req);
    logic got;
    logic expv;
    int p = period_of(code);
    bit live = (p != 0) && (num != 8'd0);
    write_cfg(code, num, 1'b0);
    check(req, run_active, live);
    for (int i = 1; i <= npk; i++) begin
      send_pkt(got);
      expv = live && (i % p == 0) && ((num == 8'hFF) || (i / p <= int'(num)));
      check(req, got, expv);
    end
    check(req, run_active, live && ((num == 8'hFF) || (npk / p < int'(num))));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, and packets pass clean with nothing armed.
    check("R1", pkt_corrupt, 1'b0);
    check("R1", run_active, 1'b0);
    for (int i = 0; i < 4; i++) begin
      send_pkt(got);
      check("R1", got, 1'b0);
    end

    // R2: period sweep with finite counts.
    run_rate(7'h01, 8'd5, 8, "R2");
    run_rate(7'h0F, 8'd3, 50, "R2");
    run_rate(7'h11, 8'd2, 25, "R2");
    run_rate(7'h23, 8'd1, 320, "R2");
    run_rate(7'h32, 8'd2, 4100, "R2");
    // R3: exponents above the ceiling clamp to it.
    run_rate(7'h41, 8'd1, 1100, "R3");
    run_rate(7'h71, 8'd2, 2100, "R3");
    // R4: zero mantissa disables.
    run_rate(7'h30, 8'd9, 10, "R4");
    run_rate(7'h50, 8'hFF, 10, "R4");
    // R6: zero count starts nothing; longer finite counts end exactly.
    run_rate(7'h01, 8'd0, 6, "R6");
    run_rate(7'h03, 8'd7, 30, "R6");
    // R7: unlimited run.
    run_rate(7'h02, 8'hFF, 40, "R7");

    // R5: restart mid-run.
    write_cfg(7'h05, 8'hFF, 1'b0);
    for (int i = 1; i <= 3; i++) begin
      send_pkt(got);
      check("R5", got, 1'b0);
    end
    write_cfg(7'h03, 8'd2, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      send_pkt(got);
      check("R5", got, (i == 3) || (i == 6));
    end
    check("R5", run_active, 1'b0);

    // R8: manual path gating.
    write_cfg(7'h00, 8'd0, 1'b1);
    glb_man_en = 1'b1;
    man_pulse();
    send_pkt(got); check("R8", got, 1'b1);
    send_pkt(got); check("R8", got, 1'b0);
    glb_man_en = 1'b0;
    man_pulse();
    send_pkt(got); check("R8", got, 1'b0);
    glb_man_en = 1'b1;
    write_cfg(7'h00, 8'd0, 1'b0);
    man_pulse();
    send_pkt(got); check("R8", got, 1'b0);

    // R9: merge and same-cycle edge.
    write_cfg(7'h00, 8'd0, 1'b1);
    man_pulse(); man_pulse(); man_pulse();
    send_pkt(got); check("R9", got, 1'b1);
    send_pkt(got); check("R9", got, 1'b0);
    @(negedge clk);
    man_err = 1'b1; pkt_start = 1'b1;
    @(negedge clk);
    man_err = 1'b0; pkt_start = 1'b0;
    check("R9", pkt_corrupt, 1'b0);
    send_pkt(got); check("R9", got, 1'b1);
    send_pkt(got); check("R9", got, 1'b0);

    // R10: manual alongside rate.
    write_cfg(7'h02, 8'hFF, 1'b1);
    man_pulse();
    send_pkt(got); check("R10", got, 1'b1);
    send_pkt(got); check("R10", got, 1'b1);
    send_pkt(got); check("R10", got, 1'b0);
    send_pkt(got); check("R10", got, 1'b1);
    write_cfg(7'h01, 8'd2, 1'b1);
    man_pulse();
    send_pkt(got); check("R10", got, 1'b1);
    send_pkt(got); check("R10", got, 1'b1);
    send_pkt(got); check("R10", got, 1'b0);
    check("R10", run_active, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule